// File: doc/BRIEF.md
# Down-Counting Interval Timer with Reload

This block is a down-counter with a small register slave using single-beat Wishbone-style cycles. Software writes a start value and a follow-on value. It then arms the counter through a control word. After that, software polls the running count to measure delays. A count of zero means the period has elapsed.

The counter runs from a three-state machine:

- **ST_IDLE**: the timer is disarmed. The count follows the start value.
- **ST_RUN**: the count drops by one on every clock.
- **ST_DONE**: the count holds at zero after expiry in single-shot use.

The machine has these transitions:

- **arm** (ST_IDLE→ST_RUN): both enable bits are found set.
- **expire** (ST_RUN→ST_DONE): the count is zero and the follow-on value is zero.
- **wrap** (ST_RUN→ST_RUN): the count is zero and the follow-on value is non-zero, so the count takes the follow-on value.
- **disarm** (ST_RUN or ST_DONE→ST_IDLE): either enable bit is found clear. The count returns to the start value, so the next arm gives a full period.

Top module: `cdown_timer`

## Requirements
- R1: After reset, all four registers read 0 and no acknowledge is pending.
- R2: A request is accepted when cyc and stb are high while ack is low. Ack is high for exactly the following cycle and carries the read data.
- R2 (register select): bus_adr holds byte-address bits 3:2. The values 0, 1, 2 and 3 select control, start value, follow-on value and count, matching byte offsets 0x0, 0x4, 0x8 and 0xC.
- R3: The timer runs only while control bits 0 and 4 are both 1. With only one of them set, the count stays at the start value.
- R4: Control reads return bits 0 and 4 as last written, and 0 in every other bit.
- R5: An enable write accepted at edge A makes the count equal the start value after edge A+1. The count then falls by one per clock.
- R6: With a non-zero follow-on value, a zero count is replaced by the follow-on value on the next clock, and counting continues from there.
- R7: With a follow-on value of 0, the count stays at 0 after expiry for as long as the timer is enabled.
- R8: Clearing the enable returns the count to the start value one clock after the control write.
- R9: Writing the start value while disabled changes the count one clock later. Writing it while running leaves the running count undisturbed.
- R10: The count register is read-only. Writes to it are acknowledged and change nothing.
- R11: The start and follow-on registers read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cyc | input | 1 | Bus cycle valid |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_adr | input | 2 | Register index (byte-address bits 3:2) |
| bus_dat_w | input | DW | Write data |
| bus_ack | output | 1 | One-cycle acknowledge |
| bus_dat_r | output | DW | Read data, valid with ack |

## Verification
The bench uses the default 32-bit data width. This lets a start value of all ones be loaded and counted, so the top bit of the decrementer is exercised.

The table uses small start and follow-on values of 0 to 10. These reach the expire, wrap and repeated-wrap transitions within a few dozen clocks, and also cover a start value of zero. Since every bus transfer takes two clocks, each read samples a known clock offset from the enable write. That offset lets the expected count be worked out exactly.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int IDX_W     = 2;
    localparam int EN_LO_BIT = 0;
    localparam int EN_HI_BIT = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } tmr_state_e;

    typedef enum logic [IDX_W-1:0] {
        RG_CTRL   = 2'd0,
        RG_START  = 2'd1,
        RG_FOLLOW = 2'd2,
        RG_COUNT  = 2'd3
    } tmr_reg_e;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc,
    input  logic              stb,
    input  logic              we,
    input  logic [IDX_W-1:0]  adr,
    input  logic [DW-1:0]     dat_w,
    input  logic [DW-1:0]     count_i,
    output logic              ack,
    output logic [DW-1:0]     dat_r,
    output logic              en_o,
    output logic [DW-1:0]     start_o,
    output logic [DW-1:0]     follow_o
);
    logic          ack_q;
    logic          en_lo_q, en_hi_q;
    logic [DW-1:0] start_q, follow_q, rd_mux, ctrl_rd;
    logic          req;
    tmr_reg_e      sel;

    assign req = cyc & stb & ~ack_q;
    assign sel = tmr_reg_e'(adr);

    always_comb begin
        ctrl_rd            = '0;
        ctrl_rd[EN_LO_BIT] = en_lo_q;
        ctrl_rd[EN_HI_BIT] = en_hi_q;
    end

    always_comb begin
        unique case (sel)
            RG_CTRL:   rd_mux = ctrl_rd;
            RG_START:  rd_mux = start_q;
            RG_FOLLOW: rd_mux = follow_q;
            RG_COUNT:  rd_mux = count_i;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q    <= 1'b0;
            dat_r    <= '0;
            en_lo_q  <= 1'b0;
            en_hi_q  <= 1'b0;
            start_q  <= '0;
            follow_q <= '0;
        end else begin
            ack_q <= req;
            if (req) dat_r <= rd_mux;
            if (req && we) begin
                unique case (sel)
                    RG_CTRL: begin
                        en_lo_q <= dat_w[EN_LO_BIT];
                        en_hi_q <= dat_w[EN_HI_BIT];
                    end
                    RG_START:  start_q  <= dat_w;
                    RG_FOLLOW: follow_q <= dat_w;
                    default:   ;
                endcase
            end
        end
    end

    assign ack      = ack_q;
    assign en_o     = en_lo_q & en_hi_q;
    assign start_o  = start_q;
    assign follow_o = follow_q;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [DW-1:0] start_val,
    input  logic [DW-1:0] follow_val,
    output logic [DW-1:0] count_o,
    output tmr_state_e    state_o
);
    localparam logic [DW-1:0] ZERO = '0;
    localparam logic [DW-1:0] ONE  = DW'(1);

    tmr_state_e    state_q, state_d;
    logic [DW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = start_val;
                if (en) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!en) begin
                    state_d = ST_IDLE;
                    cnt_d   = start_val;
                end else if (cnt_q != ZERO) begin
                    cnt_d = cnt_q - ONE;
                end else if (follow_val != ZERO) begin
                    cnt_d = follow_val;
                end else begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                if (!en) begin
                    state_d = ST_IDLE;
                    cnt_d   = start_val;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = start_val;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
    assign state_o = state_q;
endmodule

// File: rtl/cdown_timer.sv
module cdown_timer
    import tmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_cyc,
    input  logic             bus_stb,
    input  logic             bus_we,
    input  logic [IDX_W-1:0] bus_adr,
    input  logic [DW-1:0]    bus_dat_w,
    output logic             bus_ack,
    output logic [DW-1:0]    bus_dat_r
);
    logic          tmr_en;
    logic [DW-1:0] tmr_load, tmr_reload, tmr_cnt;
    tmr_state_e    tmr_state;

    tmr_regs #(.DW(DW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cyc      (bus_cyc),
        .stb      (bus_stb),
        .we       (bus_we),
        .adr      (bus_adr),
        .dat_w    (bus_dat_w),
        .count_i  (tmr_cnt),
        .ack      (bus_ack),
        .dat_r    (bus_dat_r),
        .en_o     (tmr_en),
        .start_o  (tmr_load),
        .follow_o (tmr_reload)
    );

    tmr_core #(.DW(DW)) u_core (
        .clk        (clk),
        .rst        (rst),
        .en         (tmr_en),
        .start_val  (tmr_load),
        .follow_val (tmr_reload),
        .count_o    (tmr_cnt),
        .state_o    (tmr_state)
    );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
    import tmr_pkg::*;
#(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          ack,
    input logic          en,
    input tmr_state_e    state,
    input logic [DW-1:0] cnt,
    input logic [DW-1:0] load,
    input logic [DW-1:0] reload
);
    // R2
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && en && cnt != '0) |=> cnt == $past(cnt) - DW'(1));

    // R6
    reload_take_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && en && cnt == '0 && reload != '0) |=> cnt == $past(reload));

    // R7
    oneshot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE && en) |=> cnt == '0);

    // R8
    rearm_chk: assert property (@(posedge clk) disable iff (rst)
        (!en) |=> cnt == $past(load));

    // R3
    stay_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !en) |=> state == ST_IDLE);
endmodule

bind cdown_timer tmr_chk #(.DW(DW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .ack    (bus_ack),
    .en     (tmr_en),
    .state  (tmr_state),
    .cnt    (tmr_cnt),
    .load   (tmr_load),
    .reload (tmr_reload)
);

// File: tb/sim_cdown_timer.sv
`timescale 1ns/1ps
module sim_cdown_timer;
    localparam int DW = 32;
    localparam int NV = 10;
    // each entry: {start, follow, idle cycles, expected count}
    localparam logic [127:0] VEC [NV] = '{
        {32'd10, 32'd0, 32'd0,  32'd10},
        {32'd10, 32'd0, 32'd4,  32'd6},
        {32'd5,  32'd0, 32'd5,  32'd0},
        {32'd5,  32'd0, 32'd20, 32'd0},
        {32'd3,  32'd7, 32'd4,  32'd7},
        {32'd3,  32'd7, 32'd6,  32'd5},
        {32'd0,  32'd4, 32'd1,  32'd4},
        {32'd2,  32'd2, 32'd9,  32'd2},
        {32'hFFFF_FFFF, 32'd0, 32'd3, 32'hFFFF_FFFC},
        {32'd0,  32'd0, 32'd3,  32'd0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [1:0]    adr = '0;
    logic [DW-1:0] dw  = '0;
    logic          ack;
    logic [DW-1:0] dr;
    int checks = 0, errors = 0;
    logic [DW-1:0] rv;

    always #4 clk = ~clk;

    cdown_timer #(.DW(DW)) u0 (
        .clk(clk), .rst(rst), .bus_cyc(cyc), .bus_stb(stb), .bus_we(we),
        .bus_adr(adr), .bus_dat_w(dw), .bus_ack(ack), .bus_dat_r(dr)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic w, input logic [1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] r);
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = w; adr = a; dw = d;
        @(posedge clk);
        @(negedge clk);
        if (ack !== 1'b1) begin
            errors++;
            $display("FAIL R2: actual ack %b expected 1", ack);
        end
        r = dr;
        cyc = 1'b0; stb = 1'b0; we = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        logic [DW-1:0] unused_r;
        xfer(1'b1, a, d, unused_r);
    endtask

    task automatic rd(input logic [1:0] a, output logic [DW-1:0] r);
        xfer(1'b0, a, '0, r);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 ack", {31'd0, ack}, '0);
        rd(2'd0, rv); check("R1 ctrl", rv, '0);
        rd(2'd1, rv); check("R1 start", rv, '0);
        rd(2'd2, rv); check("R1 follow", rv, '0);
        rd(2'd3, rv); check("R1 count", rv, '0);

        // R5 R6 R7 vector table
        for (int i = 0; i < NV; i++) begin
            wr(2'd0, 32'h0);
            wr(2'd1, VEC[i][127:96]);
            wr(2'd2, VEC[i][95:64]);
            wr(2'd0, 32'h11);
            repeat (int'(VEC[i][63:32])) @(negedge clk);
            rd(2'd3, rv);
            check("R5/R6/R7 table", rv, VEC[i][31:0]);
        end

        // R3 only one enable bit
        wr(2'd0, 32'h0);
        wr(2'd1, 32'd50);
        wr(2'd0, 32'h01);
        repeat (5) @(negedge clk);
        rd(2'd3, rv); check("R3 bit0 only", rv, 32'd50);
        wr(2'd0, 32'h10);
        repeat (5) @(negedge clk);
        rd(2'd3, rv); check("R3 bit4 only", rv, 32'd50);

        // R4 readback mask
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, rv); check("R4 ctrl mask", rv, 32'h11);
        repeat (3) @(negedge clk);

        // R8 disarm rearms
        wr(2'd0, 32'h0);
        rd(2'd3, rv); check("R8 rearm", rv, 32'd50);

        // R9 start write while disabled / running
        wr(2'd1, 32'd77);
        rd(2'd3, rv); check("R9 disabled load", rv, 32'd77);
        wr(2'd0, 32'h11);
        wr(2'd1, 32'd500);
        rd(2'd3, rv); check("R9 running load", rv, 32'd75);

        // R10 count register read-only
        wr(2'd0, 32'h0);
        wr(2'd3, 32'h1234);
        rd(2'd3, rv); check("R10 count write ignored", rv, 32'd500);

        // R11 readback
        wr(2'd2, 32'hABCD);
        rd(2'd2, rv); check("R11 follow", rv, 32'hABCD);
        rd(2'd1, rv); check("R11 start", rv, 32'd500);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule